// File: doc/BRIEF.md
# Quad-Port Memory with Write Arbitration

This block is a 512-word, 18-bit memory with two write ports and two read ports, all of which may be used in the same cycle. Both write ports share one write clock. Each write port carries an address, a data word, a write enable and one enable bit per 9-bit lane, so either half of a word can be updated on its own. Each read port has its own address and its own read clock. An elaboration-time choice makes the read path either registered or combinational. In registered mode both the read address and the read data are captured on the read clock.

A selectable arbiter settles conflicts between the two write ports. With the arbiter on, port 1 always wins and port 0 is dropped whenever both ports write in the same cycle. The `busy` flag then shows port-1 activity. With the arbiter off, both writes go through. `busy` then warns of a collision, meaning the same address with an overlapping lane. A system-port option reserves port 1 for a system-side master and forces the arbiter on. Initial contents come from a parameter. Reset clears only the read data registers and `busy`, and never the array.

Top module: `qp_ram_arb`

## Requirements
- R1: The array holds 512 words of 18 bits, and the two read ports return the words at their own addresses in the same cycle as writes on both write ports.
- R2: In registered mode the read address is captured on a rising read-clock edge and the word appears after the next rising edge. That word holds the contents before the writes of the edge that loads it, so a read that meets a write to the same address returns the old value.
- R3: While reset is low, both registered read outputs and `busy` are 0, and the array contents survive a reset.
- R4: Lane enable bit 0 selects data bits 8:0 and bit 1 selects bits 17:8+1 (17:9). A lane whose enable is 0 keeps its old value, and a write enable with no lane set changes nothing and counts as no write.
- R5: With the arbiter on, if both ports write in one cycle, port 0's write is dropped at any address and port 1's write lands.
- R6: With the arbiter on, `busy` is 1 in the cycle after each write-clock edge on which port 1 wrote, and 0 otherwise.
- R7: With the arbiter off, both writes of a cycle land. `busy` is 1 in the cycle after an edge on which both ports wrote the same address with at least one common lane, and 0 otherwise.
- R8: In asynchronous mode the read data follows the read address and the array with no clock, and a write is visible right after its write edge.
- R9: Before any write, every word reads as the parameter `INIT_WORD`.
- R10: Setting `SYS_PORT1` makes the block behave as with the arbiter on, even when `ARB_EN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock shared by both write ports and `busy` |
| rst_n | input | 1 | Asynchronous active-low reset of read registers and `busy` |
| wr0_en | input | 1 | Port 0 write enable |
| wr0_addr | input | 9 | Port 0 write address |
| wr0_lane | input | 2 | Port 0 lane enables (bit 0 low half, bit 1 high half) |
| wr0_data | input | 18 | Port 0 write data |
| wr1_en | input | 1 | Port 1 write enable (priority port) |
| wr1_addr | input | 9 | Port 1 write address |
| wr1_lane | input | 2 | Port 1 lane enables |
| wr1_data | input | 18 | Port 1 write data |
| rclk0 | input | 1 | Read port 0 clock |
| rd0_addr | input | 9 | Read port 0 address |
| rd0_data | output | 18 | Read port 0 data |
| rclk1 | input | 1 | Read port 1 clock |
| rd1_addr | input | 9 | Read port 1 address |
| rd1_data | output | 18 | Read port 1 data |
| busy | output | 1 | Port-1 activity (arbiter on) or collision warning (arbiter off) |

## Verification
The assertions check on every cycle the rules that involve only write-side state. These are that port 0 never gets a grant while port 1 is active under arbitration, that `busy` follows port-1 activity or the collision condition one edge later, and that a lane left disabled keeps its value. The scenarios are the only place to show the read side. That covers the two-edge registered latency, the old-data result when a read meets a write, the combinational read path, the initial contents, and the survival of the array across reset. Three instances with different options share one stimulus stream. This also shows that the system-port option gives the same results as the arbitrated instance, and that merged writes to disjoint lanes of one word both land when the arbiter is off.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  typedef enum logic {
    RD_ASYNC = 1'b0,
    RD_REG   = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/qpr_arbiter.sv
module qpr_arbiter #(
  parameter int AW     = 9,
  parameter int LANES  = 2,
  parameter bit ARB_ON = 1'b1
) (
  input  logic             we0,
  input  logic [AW-1:0]    a0,
  input  logic [LANES-1:0] be0,
  input  logic             we1,
  input  logic [AW-1:0]    a1,
  input  logic [LANES-1:0] be1,
  output logic             req0,
  output logic             req1,
  output logic             clash,
  output logic             gnt0,
  output logic             gnt1,
  output logic             busy_d
);
  // a port counts as writing only with at least one lane selected
  function automatic logic is_active(input logic we, input logic [LANES-1:0] be);
    return we && (|be);
  endfunction

  // same word and at least one shared lane
  function automatic logic hits(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                input logic [LANES-1:0] bx, input logic [LANES-1:0] by);
    return (x == y) && (|(bx & by));
  endfunction

  assign req0  = is_active(we0, be0);
  assign req1  = is_active(we1, be1);
  assign clash = req0 && req1 && hits(a0, a1, be0, be1);
  assign gnt1  = req1;

  generate
    if (ARB_ON) begin : g_arb
      assign gnt0   = req0 && !req1;
      assign busy_d = req1;
    end else begin : g_free
      assign gnt0   = req0;
      assign busy_d = clash;
    end
  endgenerate
endmodule

// File: rtl/qpr_array.sv
module qpr_array #(
  parameter int DEPTH  = 512,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter logic [LANE_W*LANES-1:0] INIT_WORD = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        gnt0,
  input  logic [$clog2(DEPTH)-1:0]    a0,
  input  logic [LANES-1:0]            be0,
  input  logic [LANE_W*LANES-1:0]     d0,
  input  logic                        gnt1,
  input  logic [$clog2(DEPTH)-1:0]    a1,
  input  logic [LANES-1:0]            be1,
  input  logic [LANE_W*LANES-1:0]     d1,
  input  logic [$clog2(DEPTH)-1:0]    ra0,
  input  logic [$clog2(DEPTH)-1:0]    ra1,
  output logic [LANE_W*LANES-1:0]     q0,
  output logic [LANE_W*LANES-1:0]     q1
);
  localparam int W = LANE_W * LANES;

  logic [W-1:0] mem [DEPTH] = '{default: INIT_WORD};

  // replace the enabled lanes of a word, keep the rest
  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old,
                                              input logic [W-1:0] din,
                                              input logic [LANES-1:0] be);
    logic [W-1:0] r;
    r = old;
    for (int l = 0; l < LANES; l++)
      if (be[l]) r[l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
    return r;
  endfunction

  logic          same_word;
  logic [W-1:0]  base1;
  assign same_word = gnt0 && (a0 == a1);
  assign base1     = same_word ? lane_merge(mem[a1], d0, be0) : mem[a1];

  always_ff @(posedge clk) begin
    if (gnt0) mem[a0] <= lane_merge(mem[a0], d0, be0);
    if (gnt1) mem[a1] <= lane_merge(base1, d1, be1);
  end

  assign q0 = mem[ra0];
  assign q1 = mem[ra1];

  // R4: a lone port-0 write without the top lane leaves that lane alone
  a_r4_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt0 && !gnt1 && !be0[LANES-1]) |=>
      mem[$past(a0)][W-1 -: LANE_W] == $past(mem[a0][W-1 -: LANE_W]));
endmodule

// File: rtl/qpr_rd_port.sv
module qpr_rd_port #(
  parameter int                 AW      = 9,
  parameter int                 W       = 18,
  parameter qpr_pkg::rd_mode_e  RD_MODE = qpr_pkg::RD_REG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] arr_addr,
  input  logic [W-1:0]  arr_data,
  output logic [W-1:0]  dout
);
  generate
    if (RD_MODE == qpr_pkg::RD_REG) begin : g_reg
      logic [AW-1:0] addr_q;
      always_ff @(posedge clk) addr_q <= addr;
      assign arr_addr = addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= arr_data;
      end
    end else begin : g_async
      assign arr_addr = addr;
      assign dout     = arr_data;
    end
  endgenerate
endmodule

// File: rtl/qp_ram_arb.sv
module qp_ram_arb #(
  parameter int                        DEPTH     = 512,
  parameter int                        LANE_W    = 9,
  parameter int                        LANES     = 2,
  parameter qpr_pkg::rd_mode_e         RD_MODE   = qpr_pkg::RD_REG,
  parameter bit                        ARB_EN    = 1'b1,
  parameter bit                        SYS_PORT1 = 1'b0,
  parameter logic [LANE_W*LANES-1:0]   INIT_WORD = '0
) (
  input  logic                          wclk,
  input  logic                          rst_n,
  input  logic                          wr0_en,
  input  logic [$clog2(DEPTH)-1:0]      wr0_addr,
  input  logic [LANES-1:0]              wr0_lane,
  input  logic [LANE_W*LANES-1:0]       wr0_data,
  input  logic                          wr1_en,
  input  logic [$clog2(DEPTH)-1:0]      wr1_addr,
  input  logic [LANES-1:0]              wr1_lane,
  input  logic [LANE_W*LANES-1:0]       wr1_data,
  input  logic                          rclk0,
  input  logic [$clog2(DEPTH)-1:0]      rd0_addr,
  output logic [LANE_W*LANES-1:0]       rd0_data,
  input  logic                          rclk1,
  input  logic [$clog2(DEPTH)-1:0]      rd1_addr,
  output logic [LANE_W*LANES-1:0]       rd1_data,
  output logic                          busy
);
  localparam int AW     = $clog2(DEPTH);
  localparam int W      = LANE_W * LANES;
  localparam bit ARB_ON = ARB_EN || SYS_PORT1;

  // events named for the assertions
  logic req0, req1, clash, gnt0, gnt1, busy_d;
  logic [AW-1:0] ra0, ra1;
  logic [W-1:0]  q0, q1;

  qpr_arbiter #(.AW(AW), .LANES(LANES), .ARB_ON(ARB_ON)) u_arb (
    .we0(wr0_en), .a0(wr0_addr), .be0(wr0_lane),
    .we1(wr1_en), .a1(wr1_addr), .be1(wr1_lane),
    .req0(req0), .req1(req1), .clash(clash),
    .gnt0(gnt0), .gnt1(gnt1), .busy_d(busy_d)
  );

  qpr_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES), .INIT_WORD(INIT_WORD)) u_mem (
    .clk(wclk), .rst_n(rst_n),
    .gnt0(gnt0), .a0(wr0_addr), .be0(wr0_lane), .d0(wr0_data),
    .gnt1(gnt1), .a1(wr1_addr), .be1(wr1_lane), .d1(wr1_data),
    .ra0(ra0), .ra1(ra1), .q0(q0), .q1(q1)
  );

  qpr_rd_port #(.AW(AW), .W(W), .RD_MODE(RD_MODE)) u_rd0 (
    .clk(rclk0), .rst_n(rst_n), .addr(rd0_addr),
    .arr_addr(ra0), .arr_data(q0), .dout(rd0_data)
  );

  qpr_rd_port #(.AW(AW), .W(W), .RD_MODE(RD_MODE)) u_rd1 (
    .clk(rclk1), .rst_n(rst_n), .addr(rd1_addr),
    .arr_addr(ra1), .arr_data(q1), .dout(rd1_data)
  );

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

  generate
    if (ARB_ON) begin : g_chk_arb
      // R5: port 0 gets no grant while port 1 is writing
      a_r5_p0_blocked: assert property (@(posedge wclk) disable iff (!rst_n)
        (req0 && req1) |-> !gnt0);
      // R6: busy follows port-1 activity one edge later
      a_r6_busy_p1: assert property (@(posedge wclk) disable iff (!rst_n)
        req1 |=> busy);
      a_r6_quiet_p1: assert property (@(posedge wclk) disable iff (!rst_n)
        !req1 |=> !busy);
    end else begin : g_chk_free
      // R7: busy flags a collision one edge later, and nothing else
      a_r7_busy_clash: assert property (@(posedge wclk) disable iff (!rst_n)
        clash |=> busy);
      a_r7_quiet: assert property (@(posedge wclk) disable iff (!rst_n)
        !clash |=> !busy);
      a_r7_both_granted: assert property (@(posedge wclk) disable iff (!rst_n)
        (req0 && req1) |-> (gnt0 && gnt1));
    end
  endgenerate
endmodule

// File: tb/sim_qp_ram_arb.sv
module sim_qp_ram_arb;
  localparam int PERIOD = 10;
  localparam logic [17:0] INIT_A = 18'h2A5A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       w0_en = 0, w1_en = 0;
  logic [8:0] w0_addr = 0, w1_addr = 0, r0_addr = 0, r1_addr = 0;
  logic [1:0] w0_lane = 0, w1_lane = 0;
  logic [17:0] w0_data = 0, w1_data = 0;

  logic [17:0] a_rd0, a_rd1, f_rd0, f_rd1, s_rd0, s_rd1;
  logic a_busy, f_busy, s_busy;

  always #(PERIOD/2) clk = ~clk;

  // u0: registered reads, arbiter on, non-zero init
  qp_ram_arb #(.RD_MODE(qpr_pkg::RD_REG), .ARB_EN(1'b1), .SYS_PORT1(1'b0), .INIT_WORD(INIT_A)) u0 (
    .wclk(clk), .rst_n(rst_n),
    .wr0_en(w0_en), .wr0_addr(w0_addr), .wr0_lane(w0_lane), .wr0_data(w0_data),
    .wr1_en(w1_en), .wr1_addr(w1_addr), .wr1_lane(w1_lane), .wr1_data(w1_data),
    .rclk0(clk), .rd0_addr(r0_addr), .rd0_data(a_rd0),
    .rclk1(clk), .rd1_addr(r1_addr), .rd1_data(a_rd1), .busy(a_busy));

  // u1: asynchronous reads, arbiter off, zero init
  qp_ram_arb #(.RD_MODE(qpr_pkg::RD_ASYNC), .ARB_EN(1'b0), .SYS_PORT1(1'b0), .INIT_WORD(18'h0)) u1 (
    .wclk(clk), .rst_n(rst_n),
    .wr0_en(w0_en), .wr0_addr(w0_addr), .wr0_lane(w0_lane), .wr0_data(w0_data),
    .wr1_en(w1_en), .wr1_addr(w1_addr), .wr1_lane(w1_lane), .wr1_data(w1_data),
    .rclk0(clk), .rd0_addr(r0_addr), .rd0_data(f_rd0),
    .rclk1(clk), .rd1_addr(r1_addr), .rd1_data(f_rd1), .busy(f_busy));

  // u2: system-port option with ARB_EN off, must match u0 (R10)
  qp_ram_arb #(.RD_MODE(qpr_pkg::RD_REG), .ARB_EN(1'b0), .SYS_PORT1(1'b1), .INIT_WORD(INIT_A)) u2 (
    .wclk(clk), .rst_n(rst_n),
    .wr0_en(w0_en), .wr0_addr(w0_addr), .wr0_lane(w0_lane), .wr0_data(w0_data),
    .wr1_en(w1_en), .wr1_addr(w1_addr), .wr1_lane(w1_lane), .wr1_data(w1_data),
    .rclk0(clk), .rd0_addr(r0_addr), .rd0_data(s_rd0),
    .rclk1(clk), .rd1_addr(r1_addr), .rd1_data(s_rd1), .busy(s_busy));

  typedef struct { int due; logic [17:0] v0; logic [17:0] v1; bit chk; string tag; } rd_item_t;
  typedef struct { int due; logic b_arb; logic b_free; string tag; } bz_item_t;
  rd_item_t q_rd[$];
  bz_item_t q_bz[$];

  logic [17:0] m_arb  [512];
  logic [17:0] m_free [512];
  int ec = 0;
  int n_chk = 0;
  int n_err = 0;

  task automatic check(input string req, input string what, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] merge(input logic [17:0] o, input logic [17:0] d, input logic [1:0] l);
    logic [17:0] r;
    r = o;
    if (l[0]) r[8:0]  = d[8:0];
    if (l[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  // driver: applies one write-clock cycle and pushes the expected results
  task automatic step(input logic e0, input int a0, input logic [1:0] l0, input logic [17:0] d0,
                      input logic e1, input int a1, input logic [1:0] l1, input logic [17:0] d1,
                      input int r0, input int r1, input bit chk, input string tag);
    logic act0, act1, clash;
    rd_item_t ri;
    bz_item_t bi;
    @(negedge clk);
    w0_en = e0; w0_addr = 9'(a0); w0_lane = l0; w0_data = d0;
    w1_en = e1; w1_addr = 9'(a1); w1_lane = l1; w1_data = d1;
    r0_addr = 9'(r0); r1_addr = 9'(r1);
    #1;
    // R8: combinational read path shows the array before this edge's writes
    if (chk && r0 != 511) check("R8", "u1 rd0", f_rd0, m_free[r0]);
    if (chk && r1 != 511) check("R8", "u1 rd1", f_rd1, m_free[r1]);
    act0  = e0 && (|l0);
    act1  = e1 && (|l1);
    clash = act0 && act1 && (a0 == a1) && (|(l0 & l1));
    if (act1) m_arb[a1] = merge(m_arb[a1], d1, l1);
    else if (act0) m_arb[a0] = merge(m_arb[a0], d0, l0);
    if (act0) m_free[a0] = merge(m_free[a0], d0, l0);
    if (act1) m_free[a1] = merge(m_free[a1], d1, l1);
    bi.due = ec + 1; bi.b_arb = act1; bi.b_free = clash; bi.tag = tag;
    q_bz.push_back(bi);
    ri.due = ec + 2; ri.v0 = m_arb[r0]; ri.v1 = m_arb[r1]; ri.chk = chk; ri.tag = tag;
    q_rd.push_back(ri);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 0, 0, 0, "R1");
  endtask

  // monitor: compares design results against queued expectations
  initial begin
    rd_item_t ri;
    bz_item_t bi;
    forever begin
      @(posedge clk);
      ec++;
      #1;
      while (q_bz.size() > 0 && q_bz[0].due == ec) begin
        bi = q_bz.pop_front();
        check(bi.tag, "u0 busy (R6)", {17'h0, a_busy}, {17'h0, bi.b_arb});
        check("R10", "u2 busy", {17'h0, s_busy}, {17'h0, bi.b_arb});
        check(bi.tag, "u1 busy (R7)", {17'h0, f_busy}, {17'h0, bi.b_free});
      end
      while (q_rd.size() > 0 && q_rd[0].due == ec) begin
        ri = q_rd.pop_front();
        if (ri.chk) begin
          check(ri.tag, "u0 rd0", a_rd0, ri.v0);
          check(ri.tag, "u0 rd1", a_rd1, ri.v1);
          check("R10", "u2 rd0", s_rd0, ri.v0);
          check("R10", "u2 rd1", s_rd1, ri.v1);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin m_arb[i] = INIT_A; m_free[i] = 18'h0; end
    // R3: outputs held at zero during reset
    repeat (3) @(negedge clk);
    #1;
    check("R3", "u0 rd0 in reset", a_rd0, 18'h0);
    check("R3", "u0 busy in reset", {17'h0, a_busy}, 18'h0);
    check("R3", "u1 busy in reset", {17'h0, f_busy}, 18'h0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 0, 2'b00, 0,        0, 0, 2'b00, 0,        5, 300, 1, "R9");
    step(1, 5, 2'b11, 18'h12345, 0, 0, 2'b00, 0,       5, 6,   1, "R1");
    step(0, 0, 2'b00, 0,        1, 6, 2'b11, 18'h0ABCD, 5, 6,  1, "R6");
    step(1, 5, 2'b01, 18'h3FFFF, 0, 0, 2'b00, 0,       5, 6,   1, "R4");
    step(1, 6, 2'b10, 18'h00000, 0, 0, 2'b00, 0,       5, 6,   1, "R4");
    step(1, 5, 2'b00, 18'h00000, 0, 0, 2'b00, 0,       5, 6,   1, "R4");
    // R5 / R7: two writes at distinct addresses
    step(1, 10, 2'b11, 18'h11111, 1, 11, 2'b11, 18'h22222, 10, 11, 1, "R5");
    // disjoint lanes of one word: merged with arbiter off, no collision
    step(1, 20, 2'b01, 18'h3FE01, 1, 20, 2'b10, 18'h15400, 10, 11, 1, "R7");
    // true collision on the word never checked in u1
    step(1, 511, 2'b11, 18'h00F0F, 1, 511, 2'b01, 18'h3F0F0, 20, 511, 1, "R7");
    // R2: read of 30 while the next edge writes it returns old data
    step(0, 0, 2'b00, 0,        0, 0, 2'b00, 0,        30, 20, 1, "R2");
    step(0, 0, 2'b00, 0,        1, 30, 2'b11, 18'h1C0DE, 30, 511, 1, "R2");
    step(0, 0, 2'b00, 0,        0, 0, 2'b00, 0,        30, 31, 1, "R8");
    idle(3);

    // R3: second reset leaves the array intact
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R3", "u0 rd1 in reset", a_rd1, 18'h0);
    check("R3", "u2 rd0 in reset", s_rd0, 18'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 2'b00, 0,        0, 0, 2'b00, 0,        5, 6,   1, "R3");
    step(0, 0, 2'b00, 0,        0, 0, 2'b00, 0,        10, 30, 1, "R3");
    idle(3);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule